// File: doc/BRIEF.md
# Serial Converter Control and Readout

This block is the digital sequencer and serial readout of a successive-approximation converter. A falling edge on the active-low convert input starts a conversion that lasts a fixed number of system clock cycles. The busy output is low for exactly that time. When the conversion ends, the word on the parallel result input is captured and becomes the word that the serial data output presents, most significant bit first. The analog side is modelled only by that parallel input.

The serial clock has two sources, chosen by a mode input. In internal mode the block makes the data clock itself during the next conversion, so the previous word streams out while the new one is being converted. In external mode a host supplies the data clock, and the block shifts one bit on each falling edge of that clock. An active-low chip select controls only the output enables of data, busy and data clock. It never blocks a conversion start. A power-down input aborts any running conversion and holds the sequencer idle.

The parallel result is sampled, not handshaken: it must be valid in the last cycle of each conversion, and there is no back-pressure. The serial side has no valid/ready pair because the data clock paces it. Choose `CONV_CYCLES` greater than `2*DATA_W`.

Top module: `adc_serial_ctrl`

## Requirements
- R1: A convert falling edge starts a conversion at any level of chip select. If `conv_n_i` is first seen low at clock edge k, `busy_o` is still high after edge k+1 and is low after edge k+2.
- R2: A convert falling edge that arrives during a running conversion is ignored. It neither lengthens the conversion nor starts a second one.
- R3: Each conversion that is not aborted keeps `busy_o` low for exactly `CONV_CYCLES` clock cycles.
- R4: The word captured from `result_i` at the end of a conversion replaces the output word. Its MSB is on `sdo_o` from the cycle in which `busy_o` returns high.
- R5: In internal mode (`ext_clk_sel_i` = 0), `dclk_o` makes `DATA_W` high pulses during the next conversion, one clock cycle each, on odd cycle counts. Bit `DATA_W-1-k` is on `sdo_o` across the k-th rising edge. The stream is the previously completed word, and `sdo_o` is 0 after the last bit.
- R6: In external mode (`ext_clk_sel_i` = 1), each falling edge of `dclk_i` shifts `sdo_o` to the next lower bit within three clock cycles, MSB first. Zeros follow the LSB.
- R7: In external mode the conversion timing does not change, and `dclk_o` makes no pulses.
- R8: When `cs_n_i` = 1, `sdo_oe_o`, `busy_oe_o` and `dclk_oe_o` are all 0. When `cs_n_i` = 0, the data and busy enables are 1, and `dclk_oe_o` is 1 only in internal mode.
- R9: While `pwrdn_i` = 1, a running conversion is aborted and `busy_o` is high after the next edge. No convert edge starts a conversion. The output word reverts to the last completed result.
- R10: A synchronous active-high reset gives `busy_o` = 1, `sdo_o` = 0 and `dclk_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_n_i | input | 1 | Convert request, falling edge starts, asynchronous |
| cs_n_i | input | 1 | Active-low chip select, gates output enables only |
| pwrdn_i | input | 1 | Power-down, holds sequencer idle |
| ext_clk_sel_i | input | 1 | 1 selects external data clock, 0 internal |
| dclk_i | input | 1 | External data clock, asynchronous |
| result_i | input | DATA_W | Parallel conversion result, sampled at conversion end |
| sdo_o | output | 1 | Serial data, MSB first |
| sdo_oe_o | output | 1 | Output enable for serial data pad |
| busy_o | output | 1 | Low while converting |
| busy_oe_o | output | 1 | Output enable for busy pad |
| dclk_o | output | 1 | Internally generated data clock |
| dclk_oe_o | output | 1 | Output enable for data clock pad |

## Verification
The hardest case to reach is a power-down that lands in the middle of an internal-mode conversion. At that point the output register already holds a partly shifted copy of the previous word, and the block must recover the whole word. The bench starts a conversion, waits until several data-clock pulses have shifted bits out, and then raises power-down. It then checks that the MSB of the earlier word is back on the data pin. A further full conversion must then stream that same earlier word, and not the partial copy or the abandoned result.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_CONV = 1'b1} seq_state_t;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/adc_fall_sync.sv
module adc_fall_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES;
  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {(LAST + 1){RESET_VAL}};
    else     chain_q <= {chain_q[LAST-1:0], async_i};
  end

  assign fall_o = chain_q[LAST] & ~chain_q[LAST-1];

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_ctl_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 30,
  parameter int unsigned DATA_W      = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic pwrdn_i,
  output logic active_o,
  output logic done_o,
  output logic abort_o,
  output logic dclk_int_o,
  output logic shift_int_o
);
  localparam int unsigned CW       = $clog2(CONV_CYCLES);
  localparam logic [CW-1:0] LAST   = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] STREAM = CW'(2 * DATA_W);

  seq_state_t state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || pwrdn_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_CONV;
          cnt_q   <= '0;
        end
        SEQ_CONV: if (cnt_q == LAST) begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign active_o    = (state_q == SEQ_CONV);
  assign done_o      = active_o && (cnt_q == LAST) && !pwrdn_i;
  assign abort_o     = active_o && pwrdn_i;
  assign dclk_int_o  = active_o && (cnt_q < STREAM) && cnt_q[0];
  assign shift_int_o = dclk_int_o && !pwrdn_i;

  p_start_any_r1: assert property (@(posedge clk) disable iff (rst)
    start_i && !active_o && !pwrdn_i |=> active_o && cnt_q == '0);
  p_ignore_edge_r2: assert property (@(posedge clk) disable iff (rst)
    active_o && cnt_q != LAST && !pwrdn_i |=> active_o && cnt_q == $past(cnt_q) + 1'b1);
  p_pwrdn_idle_r9: assert property (@(posedge clk) disable iff (rst)
    pwrdn_i |=> !active_o);
endmodule

// File: rtl/adc_out_shift.sv
module adc_out_shift #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] par_i,
  input  logic              restore_i,
  input  logic              shift_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sh_q   <= '0;
    end else if (load_i) begin
      hold_q <= par_i;
      sh_q   <= par_i;
    end else if (restore_i) begin
      sh_q <= hold_q;
    end else if (shift_i) begin
      sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo_o = sh_q[DATA_W-1];

  p_load_word_r4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> sh_q == $past(par_i) && hold_q == $past(par_i));
  p_restore_r9: assert property (@(posedge clk) disable iff (rst)
    restore_i && !load_i |=> sh_q == hold_q);
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !load_i && !restore_i && !shift_i |=> $stable(sh_q));
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_n_i,
  input  logic              cs_n_i,
  input  logic              pwrdn_i,
  input  logic              ext_clk_sel_i,
  input  logic              dclk_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              busy_oe_o,
  output logic              dclk_o,
  output logic              dclk_oe_o
);
  localparam int unsigned LW = $clog2(CONV_CYCLES + 1);

  logic conv_fall, ext_fall;
  logic active, done, abort, dclk_int, shift_int, shift_sel;

  adc_fall_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_conv_sync (
    .clk(clk), .rst(rst), .async_i(conv_n_i), .fall_o(conv_fall));

  adc_fall_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_dclk_sync (
    .clk(clk), .rst(rst), .async_i(dclk_i), .fall_o(ext_fall));

  adc_conv_seq #(.CONV_CYCLES(CONV_CYCLES), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(conv_fall), .pwrdn_i(pwrdn_i),
    .active_o(active), .done_o(done), .abort_o(abort),
    .dclk_int_o(dclk_int), .shift_int_o(shift_int));

  assign shift_sel = ext_clk_sel_i ? ext_fall : shift_int;

  adc_out_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(done), .par_i(result_i),
    .restore_i(abort), .shift_i(shift_sel), .sdo_o(sdo_o));

  assign busy_o    = !active;
  assign dclk_o    = dclk_int && !ext_clk_sel_i;
  assign sdo_oe_o  = !cs_n_i;
  assign busy_oe_o = !cs_n_i;
  assign dclk_oe_o = !cs_n_i && !ext_clk_sel_i;

  logic [LW-1:0] low_cnt_q;
  always_ff @(posedge clk) begin
    if (rst || !active) low_cnt_q <= '0;
    else                low_cnt_q <= low_cnt_q + 1'b1;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) && !$past(pwrdn_i) |-> low_cnt_q == LW'(CONV_CYCLES));
  p_dclk_in_conv_r5: assert property (@(posedge clk) disable iff (rst)
    dclk_o |-> !busy_o);
endmodule

// File: tb/test_adc_serial_ctrl.sv
module test_adc_serial_ctrl;
  localparam int W    = 12;
  localparam int CONV = 30;

  logic clk = 1'b0;
  logic rst, conv_n, cs_n, pwrdn, ext_sel, dclk_i;
  logic [W-1:0] result;
  logic sdo_o, sdo_oe_o, busy_o, busy_oe_o, dclk_o, dclk_oe_o;
  int passes = 0, fails = 0;
  logic [W-1:0] last_word;

  always #4 clk = ~clk;

  adc_serial_ctrl #(.DATA_W(W), .CONV_CYCLES(CONV)) i_adc_serial_ctrl (
    .clk(clk), .rst(rst), .conv_n_i(conv_n), .cs_n_i(cs_n), .pwrdn_i(pwrdn),
    .ext_clk_sel_i(ext_sel), .dclk_i(dclk_i), .result_i(result),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .busy_o(busy_o), .busy_oe_o(busy_oe_o),
    .dclk_o(dclk_o), .dclk_oe_o(dclk_oe_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act === exp) passes++;
    else begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_conv(input logic [W-1:0] res, input bit retrig,
                          output int lows, output logic [W-1:0] got, output logic early);
    logic prev = 1'b0;
    int nb = 0;
    result = res; lows = 0; got = '0;
    @(negedge clk) conv_n = 1'b0;
    @(negedge clk);
    @(negedge clk) early = busy_o;
    for (int i = 0; i < CONV + 12; i++) begin
      @(negedge clk);
      if (!busy_o) lows++;
      if (dclk_o && !prev && nb < W) begin got = {got[W-2:0], sdo_o}; nb++; end
      prev = dclk_o;
      if (i == 4) conv_n = 1'b1;
      if (retrig && i == 9) conv_n = 1'b0;
      if (i == 12) conv_n = 1'b1;
    end
  endtask

  task automatic t_reset;
    chk("R10 busy", busy_o, 1);
    chk("R10 sdo", sdo_o, 0);
    chk("R10 dclk", dclk_o, 0);
  endtask

  task automatic t_internal;
    int lows; logic [W-1:0] got; logic early;
    run_conv(12'hB3C, 0, lows, got, early);
    chk("R1 latency", early, 1);
    chk("R3 busy length", lows, CONV);
    chk("R5 first stream", got, 0);
    chk("R4 new MSB", sdo_o, 1);
    run_conv(12'h5A1, 0, lows, got, early);
    chk("R5 stream prev word", got, 12'hB3C);
    chk("R4 new MSB", sdo_o, 0);
    last_word = 12'h5A1;
  endtask

  task automatic t_retrig;
    int lows; logic [W-1:0] got; logic early;
    run_conv(12'hC0F, 1, lows, got, early);
    chk("R2 no extension", lows, CONV);
    chk("R2 idle after", busy_o, 1);
    chk("R2 stream", got, last_word);
    last_word = 12'hC0F;
  endtask

  task automatic t_cs;
    int lows; logic [W-1:0] got; logic early;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    chk("R8 sdo_oe off", sdo_oe_o, 0);
    chk("R8 busy_oe off", busy_oe_o, 0);
    chk("R8 dclk_oe off", dclk_oe_o, 0);
    run_conv(12'h3E7, 0, lows, got, early);
    chk("R1 start with cs high", lows, CONV);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    chk("R8 sdo_oe on", sdo_oe_o, 1);
    chk("R8 busy_oe on", busy_oe_o, 1);
    chk("R8 dclk_oe internal", dclk_oe_o, 1);
    chk("R4 word after cs", sdo_o, 0);
    last_word = 12'h3E7;
  endtask

  task automatic t_pwrdn;
    int lows; logic [W-1:0] got; logic early;
    logic [W-1:0] aborted;
    int bad = 0;
    aborted = ~last_word;
    result = aborted;
    @(negedge clk) conv_n = 1'b0;
    repeat (12) @(negedge clk);
    chk("R9 running", busy_o, 0);
    pwrdn = 1'b1;
    @(negedge clk);
    chk("R9 abort busy", busy_o, 1);
    chk("R9 restored MSB", sdo_o, last_word[W-1]);
    conv_n = 1'b1;
    repeat (3) @(negedge clk);
    conv_n = 1'b0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (!busy_o) bad++; end
    chk("R9 start blocked", bad, 0);
    conv_n = 1'b1;
    @(negedge clk) pwrdn = 1'b0;
    repeat (4) @(negedge clk);
    run_conv(12'h0F0, 0, lows, got, early);
    chk("R9 whole prior word", got, last_word);
    last_word = 12'h0F0;
  endtask

  task automatic t_ext;
    int lows; logic [W-1:0] got; logic early;
    @(negedge clk) ext_sel = 1'b1;
    @(negedge clk);
    chk("R8 dclk_oe ext", dclk_oe_o, 0);
    run_conv(12'h96D, 0, lows, got, early);
    chk("R7 busy length", lows, CONV);
    chk("R7 no internal pulses", got, 0);
    for (int b = W - 1; b >= 0; b--) begin
      chk("R6 ext bit", sdo_o, 32'(result[b]));
      dclk_i = 1'b1;
      repeat (3) @(negedge clk);
      dclk_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk("R6 zero fill", sdo_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passes, passes + fails);
    $finish;
  end

  initial begin
    rst = 1'b1; conv_n = 1'b1; cs_n = 1'b0; pwrdn = 1'b0;
    ext_sel = 1'b0; dclk_i = 1'b0; result = '0; last_word = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_internal();
    t_retrig();
    t_cs();
    t_pwrdn();
    t_ext();
    $display("%0d/%0d checks passed", passes, passes + fails);
    $finish;
  end
endmodule